// File: doc/BRIEF.md
# Automatic Serial Controller Poller

This block reads two serial game-controller ports once per frame with no help from software. Each port has a clock line driven by the block and two serial data inputs. Both ports share one latch line. On a start pulse, which stands in for the vertical-count match near the start of vertical blank, the block samples a poll-enable bit. If that bit is set, the block raises the shared latch for one phase. It then clocks sixteen bits out of both ports together and shifts them into four 16-bit result words. A busy flag is high for the whole poll.

Beside the automatic path there is a manual bit-bang path. A latch write drives the shared latch line directly. A read strobe for either port pulses that port's clock low and captures its two data lines into a small per-port read value. Every serial phase lasts `PHASE_CLKS` system clocks.

Top module: `pad_poller`

## Requirements
- R1: After reset the four result words and both manual read values read zero, except the constant ones in the port 2 read value. Busy and latch are low, and both port clocks are high.
- R2: A poll starts only on a start pulse while poll enable is 1 and the block is idle. With enable at 0 the start pulse does nothing, and the result words keep their values.
- R3: A poll holds the latch at 1 for PHASE_CLKS clocks, starting in the cycle after the start pulse. It then makes 16 low pulses on both port clocks at the same time, each low for PHASE_CLKS clocks and followed by PHASE_CLKS clocks high. The latch is 0 while clocking.
- R4: Port 1 data line 1 fills word 1, port 2 data line 1 fills word 2, port 1 data line 2 fills word 3, and port 2 data line 2 fills word 4.
- R5: The first serial bit received ends up in bit 15 of its word, and the sixteenth in bit 0.
- R6: Busy rises in the cycle after the start pulse and stays high for exactly 33*PHASE_CLKS cycles.
- R7: Outside a poll, a manual latch write sets the shared latch line to the written bit. The line stays at that value until the next write. A poll leaves the line at 0.
- R8: A manual read of a port drives only that port's clock low for PHASE_CLKS clocks and samples both of its data lines. The port 1 value is {6'b0, line2, line1}. The port 2 value is {3'b0, 3'b111, line2, line1}, with bits 4:2 always 1.
- R9: A manual latch write or manual read that arrives while busy is high is ignored. The poll result, the latch line and the manual read values are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_en | input | 1 | Automatic poll enable |
| frame_tick | input | 1 | One-cycle start pulse from the raster match |
| man_latch_wr | input | 1 | Manual latch write strobe |
| man_latch_val | input | 1 | Latch value for a manual write |
| man_rd1 | input | 1 | Manual read strobe, port 1 |
| man_rd2 | input | 1 | Manual read strobe, port 2 |
| p1_d1 | input | 1 | Port 1 serial data line 1 |
| p1_d2 | input | 1 | Port 1 serial data line 2 |
| p2_d1 | input | 1 | Port 2 serial data line 1 |
| p2_d2 | input | 1 | Port 2 serial data line 2 |
| latch_o | output | 1 | Shared latch line |
| p1_clk_o | output | 1 | Port 1 serial clock, idle high |
| p2_clk_o | output | 1 | Port 2 serial clock, idle high |
| busy | output | 1 | High while a poll runs |
| word1 | output | 16 | Result: port 1 line 1 |
| word2 | output | 16 | Result: port 2 line 1 |
| word3 | output | 16 | Result: port 1 line 2 |
| word4 | output | 16 | Result: port 2 line 2 |
| man1_q | output | 8 | Manual read value, port 1 |
| man2_q | output | 8 | Manual read value, port 2 |

## Verification
Shift-register controller models sit behind both ports. Each model loads four independent random words on the latch and shifts in ones after the last bit. Because all four streams differ, a swapped line-to-word mapping or a reversed bit order shows up at once. Directed patterns cover all zeros, all ones and a button-style word with a zero low nibble. These patterns separate constant bits and stuck lines from true shifting.

Manual reads run past bit sixteen, so the trailing ones are checked as well. One poll receives manual strobes while busy, which tests that they are ignored. A start pulse with enable low tests that the words stay unchanged.

// File: rtl/pad_poller.sv
module pad_poller #(
  parameter int PHASE_CLKS = 4,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic              frame_tick,
  input  logic              man_latch_wr,
  input  logic              man_latch_val,
  input  logic              man_rd1,
  input  logic              man_rd2,
  input  logic              p1_d1,
  input  logic              p1_d2,
  input  logic              p2_d1,
  input  logic              p2_d2,
  output logic              latch_o,
  output logic              p1_clk_o,
  output logic              p2_clk_o,
  output logic              busy,
  output logic [WORD_W-1:0] word1,
  output logic [WORD_W-1:0] word2,
  output logic [WORD_W-1:0] word3,
  output logic [WORD_W-1:0] word4,
  output logic [7:0]        man1_q,
  output logic [7:0]        man2_q
);
  localparam int PW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LATCH, S_LOW, S_HIGH, S_MLOW, S_MHIGH} st_t;

  st_t           st;
  logic [PW-1:0] ph;
  logic [BW-1:0] bc;
  logic          mport;
  logic          man_latch_q;
  logic [1:0]    m1, m2;

  wire ph_end = (ph == PW'(PHASE_CLKS - 1));

  assign busy     = (st == S_LATCH) || (st == S_LOW) || (st == S_HIGH);
  assign latch_o  = man_latch_q || (st == S_LATCH);
  assign p1_clk_o = !((st == S_LOW) || (st == S_MLOW && !mport));
  assign p2_clk_o = !((st == S_LOW) || (st == S_MLOW && mport));
  assign man1_q   = {6'b0, m1};
  assign man2_q   = {3'b0, 3'b111, m2};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= '0;
      bc          <= '0;
      mport       <= 1'b0;
      man_latch_q <= 1'b0;
      m1          <= '0;
      m2          <= '0;
      word1       <= '0;
      word2       <= '0;
      word3       <= '0;
      word4       <= '0;
    end else if (st == S_IDLE) begin
      ph <= '0;
      if (frame_tick && poll_en) begin
        st          <= S_LATCH;
        bc          <= '0;
        man_latch_q <= 1'b0;
      end else begin
        if (man_latch_wr) man_latch_q <= man_latch_val;
        if (man_rd1) begin
          st    <= S_MLOW;
          mport <= 1'b0;
        end else if (man_rd2) begin
          st    <= S_MLOW;
          mport <= 1'b1;
        end
      end
    end else begin
      ph <= ph_end ? '0 : ph + 1'b1;
      if (ph_end) begin
        case (st)
          S_LATCH: st <= S_LOW;
          S_LOW: begin
            word1 <= {word1[WORD_W-2:0], p1_d1};
            word2 <= {word2[WORD_W-2:0], p2_d1};
            word3 <= {word3[WORD_W-2:0], p1_d2};
            word4 <= {word4[WORD_W-2:0], p2_d2};
            st    <= S_HIGH;
          end
          S_HIGH: begin
            if (bc == BW'(WORD_W - 1)) st <= S_IDLE;
            else begin
              bc <= bc + 1'b1;
              st <= S_LOW;
            end
          end
          S_MLOW: begin
            if (mport) m2 <= {p2_d2, p2_d1};
            else       m1 <= {p1_d2, p1_d1};
            st <= S_MHIGH;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module pad_poller_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        poll_en,
  input logic        frame_tick,
  input logic        busy,
  input logic        latch_o,
  input logic        p1_clk_o,
  input logic        p2_clk_o,
  input logic [15:0] word1,
  input logic [15:0] word2,
  input logic [15:0] word3,
  input logic [15:0] word4,
  input logic [7:0]  man1_q,
  input logic [7:0]  man2_q
);
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_tick && poll_en));

  p_words_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(word1) && $stable(word2) && $stable(word3) && $stable(word4)));

  p_latch_no_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && latch_o) |-> (p1_clk_o && p2_clk_o));

  p_clks_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (p1_clk_o == p2_clk_o));

  p_man_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(man1_q) && $stable(man2_q)));

  p_one_clk_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (p1_clk_o || p2_clk_o));
endmodule

bind pad_poller pad_poller_chk chk_i (
  .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .frame_tick(frame_tick),
  .busy(busy), .latch_o(latch_o), .p1_clk_o(p1_clk_o), .p2_clk_o(p2_clk_o),
  .word1(word1), .word2(word2), .word3(word3), .word4(word4),
  .man1_q(man1_q), .man2_q(man2_q)
);

// File: tb/pad_poller_tb_top.sv
module pad_poller_tb_top;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_en = 1'b0, frame_tick = 1'b0;
  logic man_latch_wr = 1'b0, man_latch_val = 1'b0, man_rd1 = 1'b0, man_rd2 = 1'b0;
  logic p1_d1, p1_d2, p2_d1, p2_d2;
  logic latch_o, p1_clk_o, p2_clk_o, busy;
  logic [15:0] word1, word2, word3, word4;
  logic [7:0] man1_q, man2_q;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pad_poller #(.PHASE_CLKS(P), .WORD_W(16)) dut_i (.*);

  logic [15:0] w1a, w1b, w2a, w2b;
  logic [15:0] s1a = '1, s1b = '1, s2a = '1, s2b = '1;
  logic c1p = 1'b1, c2p = 1'b1;
  assign p1_d1 = s1a[15];
  assign p1_d2 = s1b[15];
  assign p2_d1 = s2a[15];
  assign p2_d2 = s2b[15];

  always @(posedge clk) begin
    c1p <= p1_clk_o;
    c2p <= p2_clk_o;
    if (latch_o) begin
      s1a <= w1a; s1b <= w1b; s2a <= w2a; s2b <= w2b;
    end else begin
      if (p1_clk_o && !c1p) begin
        s1a <= {s1a[14:0], 1'b1}; s1b <= {s1b[14:0], 1'b1};
      end
      if (p2_clk_o && !c2p) begin
        s2a <= {s2a[14:0], 1'b1}; s2b <= {s2b[14:0], 1'b1};
      end
    end
  end

  function automatic logic sbit(input logic [15:0] w, input int idx);
    return (idx < 16) ? w[15 - idx] : 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic poll(input logic en, input logic disturb);
    int cnt;
    logic [15:0] e1, e2, e3, e4;
    logic [7:0] m1s, m2s;
    e1 = en ? w1a : word1; e2 = en ? w2a : word2;
    e3 = en ? w1b : word3; e4 = en ? w2b : word4;
    m1s = man1_q; m2s = man2_q;
    @(negedge clk);
    poll_en = en; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    cnt = 0;
    if (en) begin
      chk("R3 latch high after tick", {latch_o, p1_clk_o, p2_clk_o}, 3'b111);
      chk("R6 busy rises", busy, 1'b1);
    end else chk("R2 disabled stays idle", busy, 1'b0);
    while (busy && cnt < 1000) begin
      cnt++;
      if (cnt == P + 1)
        chk("R3 both clocks low latch off", {latch_o, p1_clk_o, p2_clk_o}, 3'b000);
      if (disturb && cnt == 5) begin
        man_latch_wr = 1'b1; man_latch_val = 1'b1; man_rd1 = 1'b1; man_rd2 = 1'b1;
      end else begin
        man_latch_wr = 1'b0; man_rd1 = 1'b0; man_rd2 = 1'b0;
      end
      @(negedge clk);
    end
    man_latch_wr = 1'b0; man_rd1 = 1'b0; man_rd2 = 1'b0;
    if (en) chk("R6 busy length", cnt, 33 * P);
    repeat (2 * P + 2) @(negedge clk);
    chk("R4 R5 word1 port1 line1", word1, e1);
    chk("R4 R5 word2 port2 line1", word2, e2);
    chk("R4 R5 word3 port1 line2", word3, e3);
    chk("R4 R5 word4 port2 line2", word4, e4);
    if (disturb) begin
      chk("R9 latch write ignored", latch_o, 1'b0);
      chk("R9 manual reads ignored", {man1_q, man2_q}, {m1s, m2s});
      chk("R9 clocks idle", {p1_clk_o, p2_clk_o}, 2'b11);
    end
  endtask

  task automatic man_latch(input logic v);
    @(negedge clk);
    man_latch_wr = 1'b1; man_latch_val = v;
    @(negedge clk);
    man_latch_wr = 1'b0;
    chk("R7 latch follows write", latch_o, v);
  endtask

  task automatic man_read(input int port, input logic [7:0] exp);
    @(negedge clk);
    if (port == 1) man_rd1 = 1'b1; else man_rd2 = 1'b1;
    @(negedge clk);
    man_rd1 = 1'b0; man_rd2 = 1'b0;
    if (port == 1) chk("R8 only port1 clock low", {p1_clk_o, p2_clk_o}, 2'b01);
    else           chk("R8 only port2 clock low", {p1_clk_o, p2_clk_o}, 2'b10);
    repeat (2 * P + 1) @(negedge clk);
    if (port == 1) chk("R8 port1 read value", man1_q, exp);
    else           chk("R8 port2 read value", man2_q, exp);
  endtask

  initial begin
    void'($urandom(32'd4242));
    w1a = '0; w1b = '0; w2a = '0; w2b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 words zero", {word1, word2, word3, word4}, 64'h0);
    chk("R1 manual values", {man1_q, man2_q}, 16'h001C);
    chk("R1 idle lines", {busy, latch_o, p1_clk_o, p2_clk_o}, 4'b0011);

    w1a = 16'hA650; w1b = 16'h0000; w2a = 16'hFFFF; w2b = 16'h8001;
    poll(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      w1a = 16'($urandom()); w1b = 16'($urandom());
      w2a = 16'($urandom()); w2b = 16'($urandom());
      poll(1'b1, i == 2);
    end
    w1a = 16'h1234; w1b = 16'h5678; w2a = 16'h9ABC; w2b = 16'hDEF0;
    poll(1'b0, 1'b0);

    man_latch(1'b1);
    man_latch(1'b0);
    for (int k = 0; k < 18; k++)
      man_read(1, {6'b0, sbit(w1b, k), sbit(w1a, k)});
    for (int k = 0; k < 3; k++)
      man_read(2, {3'b0, 3'b111, sbit(w2b, k), sbit(w2a, k)});
    man_latch(1'b1);
    poll(1'b1, 1'b0);
    chk("R7 poll leaves latch low", latch_o, 1'b0);
    finish_run();
  end
endmodule